// File: doc/BRIEF.md
# Line Timing and Sandcastle Generator

This block derives the per-line timing pulses of a video decoder from a single strobe that marks the leading edge of horizontal sync. Every duration is a count of system-clock cycles, derived at elaboration from nanosecond parameters and a 27 MHz clock, rounded to the nearest cycle. A position counter restarts on each strobe. From it the block decodes a horizontal output pulse and a three-level sandcastle signal. The sandcastle shows active scan, the burst key and blanking. The block also decodes a gating window for the horizontal phase detector.

A second strobe marks the start of vertical blanking. A line counter then holds vertical blanking for a fixed number of lines. At every line start the block latches the signal-quality and lock inputs. From them it selects whether the phase detector is gated and which current code it receives. The current code also depends on whether the new line falls in vertical retrace. The sandcastle driver is modelled as two enables, drive-high and drive-low. With neither set, the output floats.

Top module: `line_sandcastle_gen`

## Requirements
- R1: `hpulse_o` goes high at the clock edge that samples `line_strobe_i` high and stays high for 146 cycles, which is positions 0 to 145 counted from that edge.
- R2: The burst key (`sc_drive_hi_o`=1, `sc_drive_lo_o`=0) is asserted at positions 146 to 240 after a strobe, 95 cycles. This holds in scan lines and in vertical-blanking lines alike.
- R3: During line blanking outside the burst key, at positions 0 to 145, both sandcastle enables are 0, so the output is high-impedance.
- R4: At every other position outside vertical blanking (241 onward), the sandcastle is driven low (`sc_drive_lo_o`=1, `sc_drive_hi_o`=0). The two enables are never 1 together.
- R5: `vblank_o` rises at the edge that samples `vsync_strobe_i`. It falls at the 14th line-strobe edge after that. While it is high, the sandcastle floats everywhere except during the burst key.
- R6: The phase-detector gate `pd_gate_o` opens only in lines whose start latched `weak_sig_i`=1 and `pll_locked_i`=1. In such a line it is high at positions 0 to 149 and at positions 1724 to 1727, the latter opening 4 cycles before the expected next strobe.
- R7: `pd_cur_o` is registered and changes only at a line-strobe edge. If weak and locked are both 1 it becomes 30. Otherwise it becomes 270 when the new line lies in vertical blanking and 180 when it does not.
- R8: Each strobe restarts all line timing, even in the middle of a line. Without a strobe the position saturates at 1728. From there on `hpulse_o` is 0, the gate is closed and the sandcastle is driven low, unless vertical blanking is active.
- R9: After reset, `hpulse_o`, `pd_gate_o` and `vblank_o` are 0, the sandcastle is driven low and `pd_cur_o` is 180.
- R10: If `vsync_strobe_i` and `line_strobe_i` arrive in the same cycle, the vertical strobe takes priority. That line is the first of 14 blanked lines, and it receives the retrace current code 270 unless the loop is gated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | system clock (27 MHz nominal) |
| rst_ni | input | 1 | asynchronous active-low reset |
| line_strobe_i | input | 1 | one-cycle pulse at the leading edge of horizontal sync |
| vsync_strobe_i | input | 1 | one-cycle pulse starting vertical blanking |
| weak_sig_i | input | 1 | noise detector reports a weak signal |
| pll_locked_i | input | 1 | horizontal loop is synchronized |
| hpulse_o | output | 1 | horizontal output pulse |
| sc_drive_hi_o | output | 1 | sandcastle pull-up enable (burst key) |
| sc_drive_lo_o | output | 1 | sandcastle pull-down enable (scan) |
| vblank_o | output | 1 | vertical blanking active |
| pd_gate_o | output | 1 | phase-detector gate window |
| pd_cur_o | output | 9 | phase-detector current code |

## Verification
Every output is registered from the next-state value of its counter or latch. A strobe sampled at edge E is therefore already reflected in all outputs just after E, at position 0. A position p corresponds to p edges after E. The bench drives inputs at the falling edge and updates its reference position and line count at the rising edge. It compares all outputs at the next falling edge, half a cycle after each rising edge, so each result is checked in the cycle it is due. Line lengths shorter and longer than 1728 cycles exercise the restart and saturation cases. Aligned and coincident vertical strobes exercise the 14-line count, and quality inputs toggled in mid-line show that the current code waits for the next strobe.

// File: rtl/lt_pkg.sv
package lt_pkg;

    // cycles for a duration in ns at a clock in kHz, rounded to nearest
    function automatic int ns_to_cyc(input int ns, input int clk_khz);
        longint prod;
        prod = longint'(ns) * longint'(clk_khz) + 64'sd500000;
        return int'(prod / 64'sd1000000);
    endfunction

    typedef enum logic [1:0] {
        SC_LOW   = 2'b01,
        SC_HIGH  = 2'b10,
        SC_FLOAT = 2'b00
    } sc_level_e;

endpackage

// File: rtl/lt_line_timer.sv
module lt_line_timer #(
    parameter int LINE_CYC  = 1728,
    parameter int HOUT_CYC  = 146,
    parameter int BURST_BEG = 146,
    parameter int BURST_END = 241,
    parameter int LBLK_CYC  = 235,
    parameter int GATE_END  = 150,
    parameter int GATE_PRE  = 1724
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic strobe_i,
    output logic hout_o,
    output logic burst_o,
    output logic lblank_o,
    output logic win_o
);
    localparam int CW = $clog2(LINE_CYC + 1);
    localparam logic [CW-1:0] C_LINE = CW'(LINE_CYC);
    localparam logic [CW-1:0] C_HOUT = CW'(HOUT_CYC);
    localparam logic [CW-1:0] C_BB   = CW'(BURST_BEG);
    localparam logic [CW-1:0] C_BE   = CW'(BURST_END);
    localparam logic [CW-1:0] C_LB   = CW'(LBLK_CYC);
    localparam logic [CW-1:0] C_GE   = CW'(GATE_END);
    localparam logic [CW-1:0] C_GP   = CW'(GATE_PRE);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          hout;
        logic          burst;
        logic          lblank;
        logic          win;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (strobe_i) begin
            s_d.cnt = '0;
        end else if (s_q.cnt != C_LINE) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
        s_d.hout   = (s_d.cnt < C_HOUT);
        s_d.burst  = (s_d.cnt >= C_BB) && (s_d.cnt < C_BE);
        s_d.lblank = (s_d.cnt < C_LB);
        s_d.win    = (s_d.cnt < C_GE) || ((s_d.cnt >= C_GP) && (s_d.cnt < C_LINE));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{cnt: C_LINE, hout: 1'b0, burst: 1'b0, lblank: 1'b0, win: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign hout_o   = s_q.hout;
    assign burst_o  = s_q.burst;
    assign lblank_o = s_q.lblank;
    assign win_o    = s_q.win;
endmodule

// File: rtl/lt_vblank_cnt.sv
module lt_vblank_cnt #(
    parameter int VB_LINES = 14
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic vstart_i,
    input  logic strobe_i,
    output logic active_o,
    output logic next_active_o
);
    localparam int RW = $clog2(VB_LINES + 1);
    localparam logic [RW-1:0] C_VB = RW'(VB_LINES);

    typedef struct packed {
        logic [RW-1:0] rem;
    } vb_t;

    vb_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (vstart_i) begin
            s_d.rem = C_VB;
        end else if (strobe_i && (s_q.rem != '0)) begin
            s_d.rem = s_q.rem - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{rem: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign active_o      = (s_q.rem != '0);
    assign next_active_o = (s_d.rem != '0);
endmodule

// File: rtl/lt_pd_select.sv
module lt_pd_select #(
    parameter int CUR_W       = 9,
    parameter int CUR_WEAK    = 30,
    parameter int CUR_SCAN    = 180,
    parameter int CUR_RETRACE = 270
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             strobe_i,
    input  logic             weak_i,
    input  logic             locked_i,
    input  logic             retrace_i,
    output logic             gated_o,
    output logic [CUR_W-1:0] cur_o
);
    localparam logic [CUR_W-1:0] C_WEAK = CUR_W'(CUR_WEAK);
    localparam logic [CUR_W-1:0] C_SCAN = CUR_W'(CUR_SCAN);
    localparam logic [CUR_W-1:0] C_RETR = CUR_W'(CUR_RETRACE);

    typedef struct packed {
        logic             gated;
        logic [CUR_W-1:0] cur;
    } pd_t;

    pd_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (strobe_i) begin
            s_d.gated = weak_i && locked_i;
            if (weak_i && locked_i) begin
                s_d.cur = C_WEAK;
            end else if (retrace_i) begin
                s_d.cur = C_RETR;
            end else begin
                s_d.cur = C_SCAN;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{gated: 1'b0, cur: C_SCAN};
        end else begin
            s_q <= s_d;
        end
    end

    assign gated_o = s_q.gated;
    assign cur_o   = s_q.cur;
endmodule

// File: rtl/line_sandcastle_gen.sv
module line_sandcastle_gen #(
    parameter int CLK_KHZ      = 27000,
    parameter int LINE_NS      = 64000,
    parameter int HOUT_NS      = 5400,
    parameter int BURST_NS     = 3500,
    parameter int LBLANK_NS    = 8700,
    parameter int GATE_NS      = 5700,
    parameter int GATE_LEAD_NS = 150,
    parameter int VB_LINES     = 14,
    parameter int CUR_W        = 9,
    parameter int CUR_WEAK     = 30,
    parameter int CUR_SCAN     = 180,
    parameter int CUR_RETRACE  = 270
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             line_strobe_i,
    input  logic             vsync_strobe_i,
    input  logic             weak_sig_i,
    input  logic             pll_locked_i,
    output logic             hpulse_o,
    output logic             sc_drive_hi_o,
    output logic             sc_drive_lo_o,
    output logic             vblank_o,
    output logic             pd_gate_o,
    output logic [CUR_W-1:0] pd_cur_o
);
    import lt_pkg::*;

    localparam int LINE_CYC  = ns_to_cyc(LINE_NS, CLK_KHZ);
    localparam int HOUT_CYC  = ns_to_cyc(HOUT_NS, CLK_KHZ);
    localparam int BURST_CYC = ns_to_cyc(BURST_NS, CLK_KHZ);
    localparam int LBLK_CYC  = ns_to_cyc(LBLANK_NS, CLK_KHZ);
    localparam int GATE_CYC  = ns_to_cyc(GATE_NS, CLK_KHZ);
    localparam int LEAD_CYC  = ns_to_cyc(GATE_LEAD_NS, CLK_KHZ);

    logic hout, burst, lblank, win;
    logic vb_act, vb_next, gated;
    sc_level_e sc_lvl;

    lt_line_timer #(
        .LINE_CYC (LINE_CYC),
        .HOUT_CYC (HOUT_CYC),
        .BURST_BEG(HOUT_CYC),
        .BURST_END(HOUT_CYC + BURST_CYC),
        .LBLK_CYC (LBLK_CYC),
        .GATE_END (GATE_CYC - LEAD_CYC),
        .GATE_PRE (LINE_CYC - LEAD_CYC)
    ) u_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .strobe_i(line_strobe_i),
        .hout_o  (hout),
        .burst_o (burst),
        .lblank_o(lblank),
        .win_o   (win)
    );

    lt_vblank_cnt #(
        .VB_LINES(VB_LINES)
    ) u_vblank (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .vstart_i     (vsync_strobe_i),
        .strobe_i     (line_strobe_i),
        .active_o     (vb_act),
        .next_active_o(vb_next)
    );

    lt_pd_select #(
        .CUR_W      (CUR_W),
        .CUR_WEAK   (CUR_WEAK),
        .CUR_SCAN   (CUR_SCAN),
        .CUR_RETRACE(CUR_RETRACE)
    ) u_pd (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .strobe_i (line_strobe_i),
        .weak_i   (weak_sig_i),
        .locked_i (pll_locked_i),
        .retrace_i(vb_next),
        .gated_o  (gated),
        .cur_o    (pd_cur_o)
    );

    always_comb begin
        if (burst) begin
            sc_lvl = SC_HIGH;
        end else if (lblank || vb_act) begin
            sc_lvl = SC_FLOAT;
        end else begin
            sc_lvl = SC_LOW;
        end
    end

    assign sc_drive_hi_o = sc_lvl[1];
    assign sc_drive_lo_o = sc_lvl[0];
    assign hpulse_o      = hout;
    assign vblank_o      = vb_act;
    assign pd_gate_o     = win && gated;
endmodule

// File: rtl/lt_checks.sv
module lt_checks #(
    parameter int CUR_W       = 9,
    parameter int CUR_WEAK    = 30,
    parameter int CUR_SCAN    = 180,
    parameter int CUR_RETRACE = 270
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             line_strobe_i,
    input logic             vsync_strobe_i,
    input logic             hpulse_o,
    input logic             sc_drive_hi_o,
    input logic             sc_drive_lo_o,
    input logic             vblank_o,
    input logic             pd_gate_o,
    input logic [CUR_W-1:0] pd_cur_o
);
    AST_SC_NOT_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(sc_drive_hi_o && sc_drive_lo_o)); // R4

    AST_HOUT_RISE_ON_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(hpulse_o) |-> $past(line_strobe_i)); // R1

    AST_STROBE_STARTS_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(line_strobe_i) && $past(rst_ni)) |-> (hpulse_o && !sc_drive_hi_o && !sc_drive_lo_o)); // R3

    AST_CUR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(line_strobe_i) |-> $stable(pd_cur_o)); // R7

    AST_CUR_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pd_cur_o == CUR_W'(CUR_WEAK)) || (pd_cur_o == CUR_W'(CUR_SCAN))
        || (pd_cur_o == CUR_W'(CUR_RETRACE))); // R7

    AST_GATE_ONLY_WEAK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pd_gate_o |-> (pd_cur_o == CUR_W'(CUR_WEAK))); // R6

    AST_VB_ON_VSTROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(vsync_strobe_i) && $past(rst_ni)) |-> vblank_o); // R5

    AST_VB_NO_LOW_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vblank_o |-> !sc_drive_lo_o); // R5
endmodule

bind line_sandcastle_gen lt_checks #(
    .CUR_W      (CUR_W),
    .CUR_WEAK   (CUR_WEAK),
    .CUR_SCAN   (CUR_SCAN),
    .CUR_RETRACE(CUR_RETRACE)
) u_checks (.*);

// File: tb/line_sandcastle_gen_test.sv
`timescale 1ns/1ps
module line_sandcastle_gen_test;
    localparam int LINE = 1728;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ls = 1'b0, vs = 1'b0, wk = 1'b0, lk = 1'b0;
    logic hp, sch, scl, vb, gt;
    logic [8:0] cur;

    int n_chk = 0, n_bad = 0, cyc = 0;
    int m_pos = LINE, m_vrem = 0, m_cur = 180;
    bit m_gmode = 1'b0, coinc = 1'b0;

    always #2.5 clk = ~clk;

    line_sandcastle_gen uut (
        .clk_i(clk), .rst_ni(rst_n), .line_strobe_i(ls), .vsync_strobe_i(vs),
        .weak_sig_i(wk), .pll_locked_i(lk), .hpulse_o(hp), .sc_drive_hi_o(sch),
        .sc_drive_lo_o(scl), .vblank_o(vb), .pd_gate_o(gt), .pd_cur_o(cur)
    );

    // reference model, updated at every rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pos = LINE; m_vrem = 0; m_cur = 180; m_gmode = 1'b0;
        end else begin
            if (ls) begin
                m_gmode = wk && lk;
                m_cur = (wk && lk) ? 30 : ((vs || m_vrem > 1) ? 270 : 180);
            end
            if (vs) m_vrem = 14;
            else if (ls && m_vrem > 0) m_vrem = m_vrem - 1;
            if (ls) m_pos = 0;
            else if (m_pos < LINE) m_pos = m_pos + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            if (n_bad <= 30)
                $display("FAIL %s pos=%0d actual=%0d expected=%0d", req, m_pos, act, exp);
        end
    endtask

    function automatic int exp_hi(input int p);
        return (p >= 146 && p < 241) ? 1 : 0;
    endfunction

    function automatic int exp_lo(input int p, input int vr);
        return (exp_hi(p) == 0 && p >= 235 && vr == 0) ? 1 : 0;
    endfunction

    function automatic int exp_gate(input int p, input bit g);
        return (g && (p < 150 || (p >= 1724 && p < LINE))) ? 1 : 0;
    endfunction

    task automatic compare();
        string rs;
        rs = (m_pos >= LINE) ? "R8" : (m_pos < 146 ? "R1" : "R1");
        chk(rs, int'(hp), (m_pos < 146) ? 1 : 0);
        if (exp_hi(m_pos) == 1) rs = "R2";
        else if (m_vrem > 0) rs = "R5";
        else if (m_pos < 235) rs = "R3";
        else if (m_pos >= LINE) rs = "R8";
        else rs = "R4";
        chk(rs, int'(sch), exp_hi(m_pos));
        chk(rs, int'(scl), exp_lo(m_pos, m_vrem));
        chk(coinc ? "R10" : "R5", int'(vb), (m_vrem > 0) ? 1 : 0);
        chk("R6", int'(gt), exp_gate(m_pos, m_gmode));
        chk(coinc ? "R10" : "R7", int'(cur), m_cur);
    endtask

    // one cycle: drive at falling edge, compare at next falling edge
    task automatic step(input bit l, input bit v, input bit w, input bit k);
        ls = l; vs = v; wk = w; lk = k;
        @(negedge clk);
        cyc++;
        compare();
    endtask

    task automatic line(input int len, input bit v, input bit w, input bit k, input bit rnd_q);
        step(1'b1, v, w, k);
        for (int i = 1; i < len; i++) begin
            if (rnd_q) step(1'b0, 1'b0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            else step(1'b0, 1'b0, w, k);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9", int'(hp), 0);
        chk("R9", int'(scl), 1);
        chk("R9", int'(sch), 0);
        chk("R9", int'(gt), 0);
        chk("R9", int'(vb), 0);
        chk("R9", int'(cur), 180);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        // nominal lines, strong signal
        line(LINE, 1'b0, 1'b0, 1'b1, 1'b0);
        line(LINE, 1'b0, 1'b0, 1'b0, 1'b0);
        // weak and locked: gated lines with pre-window
        line(LINE, 1'b0, 1'b1, 1'b1, 1'b0);
        line(LINE, 1'b0, 1'b1, 1'b1, 1'b0);
        // vertical blanking aligned with a strobe (R10), strong signal
        coinc = 1'b1;
        for (int j = 0; j < 15; j++) line(LINE / 4, (j == 0), 1'b0, 1'b1, 1'b0);
        coinc = 1'b0;
        // vertical strobe in mid-line, weak and locked
        line(300, 1'b0, 1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b1, 1'b1);
        for (int j = 0; j < 15; j++) line(200, 1'b0, (j % 3 == 0), 1'b1, 1'b0);
        // long gap: saturation (R8)
        line(LINE + 40, 1'b0, 1'b1, 1'b1, 1'b0);
        // early restart in burst key and in the gate window
        line(180, 1'b0, 1'b0, 1'b1, 1'b0);
        line(100, 1'b0, 1'b1, 1'b1, 1'b0);
        // random line lengths and quality toggles within lines
        for (int j = 0; j < 24; j++) begin
            line($urandom_range(120, LINE + 60), ($urandom_range(0, 5) == 0),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'b1);
        end
        ls = 1'b0; vs = 1'b0;
        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #950000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired after %0d cycles", cyc);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule